// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

This block shifts a data word left or right by an amount that can change on every cycle. One of four operations is picked by a two-bit code: logical left, logical right, arithmetic left, or arithmetic right. A separate signedness input tells the arithmetic right shift whether the word is a two's-complement value whose sign must be kept. Arithmetic left is handled as the same operation as logical left, because a left shift never has to fill with the sign.

The shifter is a chain of multiplexer stages, one for each bit of the amount. Stage k either moves the word by 2^k places or passes it through unchanged. Every stage inserts the same fill bit into the positions it vacates. That fill bit is chosen once, from the operation code, the signedness input and the most significant bit of the original input word. A parameter adds one output register after the chain. Without it the result is purely combinational.

Top module: `bshift_top`

## Requirements
- R1: With operation code 2'b00, the result is the input moved toward the MSB by `amount` places. The vacated low bits are 0, and bits pushed beyond the MSB are lost.
- R2: With operation code 2'b01, the result is the input moved toward the LSB by `amount` places, with the vacated high bits always 0.
- R3: Operation code 2'b10 gives exactly the same result as code 2'b00 for every input, amount and signedness value.
- R4: With operation code 2'b11 and `is_signed` high, the vacated high bits take the MSB of the original input. With `is_signed` low, code 2'b11 gives exactly the result of code 2'b01.
- R5: The operation code is decoded as follows: bit 0 set means a right shift, and both bits set means a shift that may fill with the sign.
- R6: An amount of 0 returns the input unchanged under every operation code.
- R7: At the largest amount (DATA_W-1), an arithmetic right shift of a signed word with MSB 1 gives all ones. Every other case at that amount leaves at most one bit set.
- R8: With OUT_REG=1, the result shows the value for the inputs sampled at a rising clock edge and holds it until the next edge. A clock edge with `rst_n` low clears the result to 0.
- R9: With OUT_REG=0, the result follows the inputs in the same cycle, with no clock edge in between.
- R10: For an 8-bit word, 8'hF8 shifted right by 1 gives 8'hFC with code 2'b11 and `is_signed` high, and gives 8'h7C with code 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the assertions |
| rst_n | input | 1 | Synchronous active-low reset; clears the output register |
| data_in | input | DATA_W | Word to be shifted |
| amount | input | AMT_W | Shift distance, from 0 to DATA_W-1 |
| op | input | 2 | Operation: 00 logical left, 01 logical right, 10 arithmetic left, 11 arithmetic right |
| is_signed | input | 1 | Treat `data_in` as signed for the arithmetic right shift |
| result | output | DATA_W | Shifted word, registered when OUT_REG=1 |

## Verification
On every cycle, the assertions check the combinational chain output against the operands. They cover the pass-through at amount zero, the zero fill after a left shift and the zero fill after an unsigned right shift, the sign fill at the top bit, and the all-ones or at-most-one-bit outcome at the largest amount. Only the bench's scenarios can show that every single bit position is correct, that the arithmetic left shift matches the logical left shift bit for bit, and the register's one-cycle latency, hold and reset clearing. The bench shows this by sweeping an 8-bit registered instance through every operand, amount, code and flag, and by driving a 32-bit combinational instance with corner words and random words.

// File: rtl/bshift_pkg.sv
// Package: shared operation codes for the barrel shifter.
// Assumes: op bit 0 selects a right shift, and both bits set allow a sign fill.
package bshift_pkg;

    typedef enum logic [1:0] {
        OP_LSL = 2'b00,
        OP_LSR = 2'b01,
        OP_ASL = 2'b10,
        OP_ASR = 2'b11
    } shift_op_e;

endpackage

// File: rtl/bshift_fill_sel.sv
// Module: bshift_fill_sel
// Decodes the operation once for the whole chain: the direction of the
// shift and the bit every stage inserts into the vacated positions.
// Assumes: sign_bit is the MSB of the original input, not of any stage.
module bshift_fill_sel
    import bshift_pkg::*;
(
    input  logic [1:0] op,
    input  logic       is_signed,
    input  logic       sign_bit,
    output logic       go_right,
    output logic       fill_bit
);

    // Direction and fill decode, purely combinational.
    always_comb begin
        go_right = op[0];
        fill_bit = 1'b0;
        if (shift_op_e'(op) == OP_ASR && is_signed) begin
            fill_bit = sign_bit;
        end
    end

endmodule

// File: rtl/bshift_stage.sv
// Module: bshift_stage
// One level of the shifter. It moves the word by DIST places when enabled,
// and passes it through unchanged otherwise.
// Assumes: 0 < DIST < W. A left move always fills with 0.
module bshift_stage #(
    parameter int W    = 32,
    parameter int DIST = 1
) (
    input  logic [W-1:0] din,
    input  logic         en,
    input  logic         go_right,
    input  logic         fill_bit,
    output logic [W-1:0] dout
);

    logic [W-1:0] moved_left;
    logic [W-1:0] moved_right;

    // Both candidate moves are plain rewiring plus the fill.
    always_comb begin
        moved_left  = {din[W-1-DIST:0], {DIST{1'b0}}};
        moved_right = {{DIST{fill_bit}}, din[W-1:DIST]};
    end

    // Select: pass through, or take the move in the decoded direction.
    always_comb begin
        if (!en) begin
            dout = din;
        end else if (go_right) begin
            dout = moved_right;
        end else begin
            dout = moved_left;
        end
    end

endmodule

// File: rtl/bshift_top.sv
// Module: bshift_top
// Variable-distance shifter built as a chain of AMT_W stages. Stage k moves
// the word by 2**k places when bit k of the amount is set. An optional
// output register (OUT_REG=1) sits behind the chain and is cleared by a
// synchronous active-low reset.
// Assumes: DATA_W is a power of two, at least 4.
module bshift_top
    import bshift_pkg::*;
#(
    parameter  int DATA_W  = 32,
    parameter  bit OUT_REG = 1'b1,
    localparam int AMT_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic [AMT_W-1:0]  amount,
    input  logic [1:0]        op,
    input  logic              is_signed,
    output logic [DATA_W-1:0] result
);

    localparam logic [AMT_W-1:0] AMT_MAX = AMT_W'(DATA_W - 1);

    logic              go_right;
    logic              fill_bit;
    logic [DATA_W-1:0] chain [AMT_W+1];
    logic [DATA_W-1:0] shifted;

    // The fill bit is taken from the original input MSB.
    bshift_fill_sel u_fill (
        .op        (op),
        .is_signed (is_signed),
        .sign_bit  (data_in[DATA_W-1]),
        .go_right  (go_right),
        .fill_bit  (fill_bit)
    );

    assign chain[0] = data_in;

    // One stage per bit of the amount.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        bshift_stage #(
            .W    (DATA_W),
            .DIST (1 << k)
        ) u_stage (
            .din      (chain[k]),
            .en       (amount[k]),
            .go_right (go_right),
            .fill_bit (fill_bit),
            .dout     (chain[k+1])
        );
    end

    assign shifted = chain[AMT_W];

    if (OUT_REG) begin : g_reg
        logic [DATA_W-1:0] result_q;
        // Output register: synchronous clear, otherwise capture the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result_q <= '0;
            end else begin
                result_q <= shifted;
            end
        end
        assign result = result_q;
    end else begin : g_comb
        assign result = shifted;
    end

    // Assertions on the chain output against the operands.
    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (amount == '0) |-> (shifted == data_in)); // R6

    AST_LEFT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!op[0] && amount != '0) |-> (shifted[0] == 1'b0)); // R1

    AST_UNSIGNED_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op[0] && !(op[1] && is_signed) && amount != '0) |-> (shifted[DATA_W-1] == 1'b0)); // R2

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b11 && is_signed) |-> (shifted[DATA_W-1] == data_in[DATA_W-1])); // R4

    AST_MAX_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (amount == AMT_MAX && op == 2'b11 && is_signed && data_in[DATA_W-1])
        |-> (&shifted)); // R7

    AST_MAX_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (amount == AMT_MAX && !(op == 2'b11 && is_signed && data_in[DATA_W-1]))
        |-> ($countones(shifted) <= 1)); // R7

endmodule

// File: tb/tb_bshift_top.sv
// Bench: an exhaustive sweep of an 8-bit registered instance, plus corner
// and random words on a 32-bit combinational instance. Expected values come
// from arithmetic on the requirements.
module tb_bshift_top;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 8;
    localparam int BW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [SW-1:0] s_data = '0;
    logic [2:0]    s_amt = '0;
    logic [1:0]    s_op = '0;
    logic          s_sg = 1'b0;
    logic [SW-1:0] s_res;

    logic [BW-1:0] b_data = '0;
    logic [4:0]    b_amt = '0;
    logic [1:0]    b_op = '0;
    logic          b_sg = 1'b0;
    logic [BW-1:0] b_res;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bshift_top #(.DATA_W(SW), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .data_in(s_data), .amount(s_amt),
        .op(s_op), .is_signed(s_sg), .result(s_res)
    );

    bshift_top #(.DATA_W(BW), .OUT_REG(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .data_in(b_data), .amount(b_amt),
        .op(b_op), .is_signed(b_sg), .result(b_res)
    );

    // Expected value from the requirements, for any width up to 32.
    function automatic logic [31:0] model(input int w, input logic [31:0] d,
                                          input int a, input logic [1:0] op,
                                          input logic sg);
        logic [31:0] m;
        logic [31:0] r;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        d = d & m;
        case (op)
            2'b00, 2'b10: r = (d << a) & m;
            2'b01:        r = d >> a;
            default: begin
                if (sg && d[w-1]) r = (d >> a) | (m & ~(m >> a));
                else              r = d >> a;
            end
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] op, input int a, input int amax);
        if (a == 0)    return "R6";
        if (a == amax) return "R7";
        case (op)
            2'b00:   return "R1 R5";
            2'b01:   return "R2 R5";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Small instance: reset, exhaustive sweep, hold, latency, reset clear.
    initial begin : small_seq
        logic [31:0] prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset", 32'(s_res), 32'h0);
        rst_n = 1'b1;
        prev = 32'h0;
        for (int d = 0; d < 256; d++) begin
            for (int a = 0; a < SW; a++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int g = 0; g < 2; g++) begin
                        s_data = d[SW-1:0];
                        s_amt  = a[2:0];
                        s_op   = o[1:0];
                        s_sg   = g[0];
                        #1;
                        check("R8 hold", 32'(s_res), prev);
                        @(posedge clk);
                        @(negedge clk);
                        prev = model(SW, 32'(d), a, o[1:0], g[0]);
                        check(tag_of(o[1:0], a, SW-1), 32'(s_res), prev);
                    end
                end
            end
        end
        // Shift example on the 8-bit instance.
        s_data = 8'hF8; s_amt = 3'd1; s_op = 2'b11; s_sg = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 sign", 32'(s_res), 32'h0000_00FC);
        s_op = 2'b01;
        @(posedge clk); @(negedge clk);
        check("R10 zero", 32'(s_res), 32'h0000_007C);
        s_op = 2'b10; s_amt = 3'd1; s_data = 8'hC3;
        @(posedge clk); @(negedge clk);
        check("R3 asl", 32'(s_res), 32'h0000_0086);
        // Reset during live inputs clears the register.
        s_data = 8'hFF; s_amt = 3'd0; s_op = 2'b00;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 clear", 32'(s_res), 32'h0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R8 after reset", 32'(s_res), 32'h0000_00FF);
        done = 1'b1;
    end

    // Wide instance: corner words on every setting, then random words.
    initial begin : wide_seq
        logic [31:0] corners [6];
        logic [31:0] rd;
        logic [31:0] ex;
        int ra;
        logic [1:0] ro;
        logic rg;
        corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
        corners[2] = 32'h8000_0000; corners[3] = 32'h0000_0001;
        corners[4] = 32'h7FFF_FFFF; corners[5] = 32'hA5A5_C3C3;
        @(posedge rst_n);
        @(negedge clk);
        for (int c = 0; c < 6; c++) begin
            for (int a = 0; a < BW; a++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int g = 0; g < 2; g++) begin
                        b_data = corners[c]; b_amt = a[4:0];
                        b_op = o[1:0]; b_sg = g[0];
                        #1;
                        ex = model(BW, corners[c], a, o[1:0], g[0]);
                        check({"R9 ", tag_of(o[1:0], a, BW-1)}, b_res, ex);
                    end
                end
            end
        end
        for (int i = 0; i < 3000; i++) begin
            rd = $urandom;
            ra = int'($urandom % BW);
            ro = 2'($urandom);
            rg = 1'($urandom);
            b_data = rd; b_amt = ra[4:0]; b_op = ro; b_sg = rg;
            #1;
            ex = model(BW, rd, ra, ro, rg);
            check({"R9 ", tag_of(ro, ra, BW-1)}, b_res, ex);
            // Arithmetic left must equal logical left.
            b_op = 2'b10;
            #1;
            check("R3 wide", b_res, model(BW, rd, ra, 2'b00, rg));
            // Unsigned arithmetic right must equal logical right.
            b_op = 2'b11; b_sg = 1'b0;
            #1;
            check("R4 unsigned", b_res, model(BW, rd, ra, 2'b01, 1'b0));
        end
    end

    // Completion and watchdog.
    initial begin
        fork
            wait (done);
            begin
                #(CLK_PERIOD * 150000);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        #(CLK_PERIOD * 2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule